// File: doc/BRIEF.md
# Indirect Management Register Access Engine

This engine sits on the master side of a management bus and turns one register read or write request into the short series of bus operations that a switch-class target needs. The target may answer at one strapped bus address only. In that case it exposes a command word at register 0 and a data word at register 1. Every internal register is reached through that pair. The command word carries a busy flag in bit 15.

A requester presents a device address, a register number, a write flag and a write word, then waits for a one-cycle completion. The completion carries the read data, a bus-error flag and a timeout flag. The strap input gives the switch's bus address. When that address is zero, the engine skips the indirection and makes one plain bus access. The bit-level serial framing is not part of this block. Each bus operation is a request with a valid/ready handshake, followed by one response that carries data and an error flag.

Top module: `regacc_seq`

## Requirements
- R1: When `sw_addr` is 0, a request produces exactly one bus operation to (`req_dev`, `req_reg`) with the request's write flag and write word. A read completes with the response data.
- R2: When `sw_addr` is not 0, the first bus operations are reads of register 0 at `sw_addr`, repeated until a response has bit 15 clear. The other 15 bits of that response have no effect.
- R3: A poll phase gives up after 16 reads that all return bit 15 set. It then completes with `cpl_timeout`=1 and issues no further operation. If 15 busy reads are followed by one clear read, the sequence goes on.
- R4: An indirect read writes 0x9800 | (dev<<5) | reg to register 0 at `sw_addr`, then polls register 0 again, then reads register 1 at `sw_addr`. That last response is returned on `cpl_rdata`.
- R5: An indirect write writes the write word to register 1 at `sw_addr`, then 0x9400 | (dev<<5) | reg to register 0, then polls register 0. It completes with no data read.
- R6: A bus response with its error flag set ends the sequence at once. The completion then has `cpl_err`=1, `cpl_timeout`=0 and `cpl_rdata`=0, and no further bus operation follows.
- R7: `req_ready` is low from the cycle after a request is accepted until the completion cycle, in which it is high again.
- R8: While `bus_req_valid` is high and `bus_req_ready` is low, the bus request and all of its fields stay unchanged. No new bus request is raised while a response is outstanding.
- R9: `cpl_valid` is a single-cycle pulse. `cpl_err` and `cpl_timeout` are never both set. `cpl_rdata` is 0 for writes and for failed requests.
- R10: After reset, `req_ready`=1, `bus_req_valid`=0 and `cpl_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_addr | input | 5 | Strapped switch bus address; 0 selects direct access |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dev | input | 5 | Target device address |
| req_reg | input | 5 | Target register number |
| req_wdata | input | 16 | Write word |
| cpl_valid | output | 1 | One-cycle completion pulse |
| cpl_err | output | 1 | Completion ended by a bus error |
| cpl_timeout | output | 1 | Completion ended by the poll limit |
| cpl_rdata | output | 16 | Read result |
| bus_req_valid | output | 1 | Bus operation offered |
| bus_req_ready | input | 1 | Bus operation taken |
| bus_req_write | output | 1 | Bus operation is a write |
| bus_req_phy | output | 5 | Bus address of the operation |
| bus_req_reg | output | 5 | Register number of the operation |
| bus_req_wdata | output | 16 | Word written by the operation |
| bus_rsp_valid | input | 1 | Bus response present |
| bus_rsp_err | input | 1 | Bus response error flag |
| bus_rsp_rdata | input | 16 | Bus response data |

## Verification
The sequencer state shows itself on the bus one operation at a time. A wrong state appears at the latest at the next bus handshake, as an unexpected address, register, direction or command word. A poll counter that is off by one either adds or drops a poll read, or moves the timeout completion by one full bus round trip. A wrong abort path shows up as a bus operation after an error response, or as a completion whose flags and data disagree with the response that ended the sequence.

// File: rtl/regacc_pkg.sv
`timescale 1ns/1ps
package regacc_pkg;
    localparam int AW         = 5;
    localparam int DW         = 16;
    localparam int POLL_LIMIT = 16;
    localparam int BUSY_BIT   = DW - 1;
    localparam logic [AW-1:0] CMD_REG  = AW'(0);
    localparam logic [AW-1:0] DATA_REG = AW'(1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIRECT,
        ST_POLL_PRE,
        ST_WDATA,
        ST_CMD,
        ST_POLL_POST,
        ST_RDATA
    } st_e;

    typedef struct packed {
        st_e           st;
        logic          wait_rsp;
        logic          wr;
        logic [AW-1:0] dev;
        logic [AW-1:0] rnum;
        logic [AW-1:0] sw;
        logic [DW-1:0] wdata;
        logic          cpl;
        logic          err;
        logic          tmo;
        logic [DW-1:0] rdata;
    } ctx_t;
endpackage

// File: rtl/regacc_cmd_enc.sv
`timescale 1ns/1ps
module regacc_cmd_enc
    import regacc_pkg::*;
(
    input  logic          is_wr,
    input  logic [AW-1:0] dev,
    input  logic [AW-1:0] rnum,
    output logic [DW-1:0] word
);
    // start bit, two zero bits, fixed-one bit, read-op bit, write-op bit, dev, reg
    localparam logic [3:0] HEAD = 4'b1001;

    always_comb begin
        word = {HEAD, ~is_wr, is_wr, dev, rnum};
    end
endmodule

// File: rtl/regacc_poll_ctr.sv
`timescale 1ns/1ps
module regacc_poll_ctr #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    assign last = (cnt_q == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    AST_POLL_STOPS_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        last |-> !inc) else $error("poll count stepped past its limit"); // R3
endmodule

// File: rtl/regacc_seq.sv
`timescale 1ns/1ps
module regacc_seq
    import regacc_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] sw_addr,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_dev,
    input  logic [AW-1:0] req_reg,
    input  logic [DW-1:0] req_wdata,
    output logic          cpl_valid,
    output logic          cpl_err,
    output logic          cpl_timeout,
    output logic [DW-1:0] cpl_rdata,
    output logic          bus_req_valid,
    input  logic          bus_req_ready,
    output logic          bus_req_write,
    output logic [AW-1:0] bus_req_phy,
    output logic [AW-1:0] bus_req_reg,
    output logic [DW-1:0] bus_req_wdata,
    input  logic          bus_rsp_valid,
    input  logic          bus_rsp_err,
    input  logic [DW-1:0] bus_rsp_rdata
);
    ctx_t          ctx_d, ctx_q;
    logic [DW-1:0] cmd_word;
    logic          is_poll;
    logic          busy_seen;
    logic          poll_last;
    logic          poll_inc;

    regacc_cmd_enc u_enc (
        .is_wr (ctx_q.wr),
        .dev   (ctx_q.dev),
        .rnum  (ctx_q.rnum),
        .word  (cmd_word)
    );

    assign is_poll   = (ctx_q.st == ST_POLL_PRE) || (ctx_q.st == ST_POLL_POST);
    assign busy_seen = bus_rsp_rdata[BUSY_BIT];
    assign poll_inc  = is_poll && ctx_q.wait_rsp && bus_rsp_valid && !bus_rsp_err
                       && busy_seen && !poll_last;

    regacc_poll_ctr #(.LIMIT(POLL_LIMIT)) u_poll (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!is_poll),
        .inc   (poll_inc),
        .last  (poll_last)
    );

    // bus operation implied by the current step
    always_comb begin
        bus_req_valid = (ctx_q.st != ST_IDLE) && !ctx_q.wait_rsp;
        bus_req_write = 1'b0;
        bus_req_phy   = ctx_q.sw;
        bus_req_reg   = CMD_REG;
        bus_req_wdata = '0;
        case (ctx_q.st)
            ST_DIRECT: begin
                bus_req_write = ctx_q.wr;
                bus_req_phy   = ctx_q.dev;
                bus_req_reg   = ctx_q.rnum;
                bus_req_wdata = ctx_q.wdata;
            end
            ST_WDATA: begin
                bus_req_write = 1'b1;
                bus_req_reg   = DATA_REG;
                bus_req_wdata = ctx_q.wdata;
            end
            ST_CMD: begin
                bus_req_write = 1'b1;
                bus_req_wdata = cmd_word;
            end
            ST_RDATA: begin
                bus_req_reg   = DATA_REG;
            end
            default: begin
            end
        endcase
    end

    // next-state computation
    always_comb begin
        ctx_d     = ctx_q;
        ctx_d.cpl = 1'b0;
        if (ctx_q.st == ST_IDLE) begin
            if (req_valid) begin
                ctx_d.st       = (sw_addr == '0) ? ST_DIRECT : ST_POLL_PRE;
                ctx_d.wait_rsp = 1'b0;
                ctx_d.wr       = req_write;
                ctx_d.dev      = req_dev;
                ctx_d.rnum     = req_reg;
                ctx_d.sw       = sw_addr;
                ctx_d.wdata    = req_wdata;
                ctx_d.err      = 1'b0;
                ctx_d.tmo      = 1'b0;
                ctx_d.rdata    = '0;
            end
        end else if (!ctx_q.wait_rsp) begin
            if (bus_req_ready) begin
                ctx_d.wait_rsp = 1'b1;
            end
        end else if (bus_rsp_valid) begin
            ctx_d.wait_rsp = 1'b0;
            if (bus_rsp_err) begin
                ctx_d.st  = ST_IDLE;
                ctx_d.cpl = 1'b1;
                ctx_d.err = 1'b1;
            end else begin
                case (ctx_q.st)
                    ST_DIRECT: begin
                        ctx_d.st  = ST_IDLE;
                        ctx_d.cpl = 1'b1;
                        if (!ctx_q.wr) begin
                            ctx_d.rdata = bus_rsp_rdata;
                        end
                    end
                    ST_POLL_PRE, ST_POLL_POST: begin
                        if (busy_seen) begin
                            if (poll_last) begin
                                ctx_d.st  = ST_IDLE;
                                ctx_d.cpl = 1'b1;
                                ctx_d.tmo = 1'b1;
                            end
                        end else if (ctx_q.st == ST_POLL_PRE) begin
                            ctx_d.st = ctx_q.wr ? ST_WDATA : ST_CMD;
                        end else if (ctx_q.wr) begin
                            ctx_d.st  = ST_IDLE;
                            ctx_d.cpl = 1'b1;
                        end else begin
                            ctx_d.st = ST_RDATA;
                        end
                    end
                    ST_WDATA: ctx_d.st = ST_CMD;
                    ST_CMD:   ctx_d.st = ST_POLL_POST;
                    ST_RDATA: begin
                        ctx_d.st    = ST_IDLE;
                        ctx_d.cpl   = 1'b1;
                        ctx_d.rdata = bus_rsp_rdata;
                    end
                    default:  ctx_d.st = ST_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q <= '0;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign req_ready   = (ctx_q.st == ST_IDLE);
    assign cpl_valid   = ctx_q.cpl;
    assign cpl_err     = ctx_q.cpl & ctx_q.err;
    assign cpl_timeout = ctx_q.cpl & ctx_q.tmo;
    assign cpl_rdata   = ctx_q.cpl ? ctx_q.rdata : '0;

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready) else $error("accepted while busy"); // R7
    AST_READY_AT_CPL: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |-> req_ready) else $error("not idle at completion"); // R7
    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && !bus_req_ready) |=> (bus_req_valid && $stable(bus_req_write)
        && $stable(bus_req_phy) && $stable(bus_req_reg) && $stable(bus_req_wdata)))
        else $error("bus request changed while stalled"); // R8
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && bus_req_ready) |=> !bus_req_valid) else $error("second operation in flight"); // R8
    AST_CPL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |=> !cpl_valid) else $error("completion longer than one cycle"); // R9
    AST_CPL_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |-> !(cpl_err && cpl_timeout)) else $error("both failure flags"); // R9
    AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && (cpl_err || cpl_timeout)) |-> (cpl_rdata == '0)) else $error("data on failure"); // R6
endmodule

// File: tb/sim_regacc_seq.sv
`timescale 1ns/1ps
module sim_regacc_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  sw_addr = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [4:0]  req_dev = '0;
    logic [4:0]  req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic        cpl_valid, cpl_err, cpl_timeout;
    logic [15:0] cpl_rdata;
    logic        bus_req_valid;
    logic        bus_req_ready = 1'b1;
    logic        bus_req_write;
    logic [4:0]  bus_req_phy, bus_req_reg;
    logic [15:0] bus_req_wdata;
    logic        bus_rsp_valid = 1'b0;
    logic        bus_rsp_err = 1'b0;
    logic [15:0] bus_rsp_rdata = '0;

    always #10 clk = ~clk;

    regacc_seq u0 (
        .clk(clk), .rst_n(rst_n), .sw_addr(sw_addr),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_dev(req_dev), .req_reg(req_reg), .req_wdata(req_wdata),
        .cpl_valid(cpl_valid), .cpl_err(cpl_err), .cpl_timeout(cpl_timeout),
        .cpl_rdata(cpl_rdata),
        .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
        .bus_req_write(bus_req_write), .bus_req_phy(bus_req_phy),
        .bus_req_reg(bus_req_reg), .bus_req_wdata(bus_req_wdata),
        .bus_rsp_valid(bus_rsp_valid), .bus_rsp_err(bus_rsp_err),
        .bus_rsp_rdata(bus_rsp_rdata)
    );

    int          n_chk = 0;
    int          n_fail = 0;
    logic [15:0] tmem [32][32];
    logic [15:0] t_data = '0;
    int          busy_left = 0;
    int          post_busy_v = 0;
    int          txn_no = 0;
    int          err_idx_v = 0;
    int          rsp_lat = 0;
    int          cyc = 0;
    bit          stall_mode = 1'b0;
    logic [26:0] expq[$];
    bit          pend = 1'b0;
    int          pcnt = 0;
    bit          perr = 1'b0;
    logic [15:0] pdata = '0;
    bit          held_v = 1'b0;
    logic [26:0] held_op = '0;
    logic [26:0] cur_op;
    logic [26:0] exp_op;
    logic [15:0] r_data;
    bit          r_err;

    assign cur_op = {bus_req_write, bus_req_phy, bus_req_reg,
                     bus_req_write ? bus_req_wdata : 16'h0000};

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // bus target model: command/data pair at sw_addr, flat register space elsewhere
    always @(negedge clk) begin
        if (!rst_n) begin
            bus_rsp_valid = 1'b0;
            pend = 1'b0;
        end else begin
            cyc++;
            bus_rsp_valid = 1'b0;
            bus_rsp_err   = 1'b0;
            if (pend) begin
                if (pcnt == 0) begin
                    bus_rsp_valid = 1'b1;
                    bus_rsp_err   = perr;
                    bus_rsp_rdata = pdata;
                    pend = 1'b0;
                end else begin
                    pcnt--;
                end
            end
            if (held_v) begin
                chk(bus_req_valid && (cur_op == held_op), "R8 stalled request held", 32'(cur_op), 32'(held_op));
                held_v = 1'b0;
            end
            bus_req_ready = stall_mode ? ((cyc % 3) == 0) : 1'b1;
            if (bus_req_valid && !bus_req_ready) begin
                held_v  = 1'b1;
                held_op = cur_op;
            end
            if (bus_req_valid && bus_req_ready) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R2/R4/R5/R6 unexpected bus operation", 32'(cur_op), 32'h0);
                end else begin
                    exp_op = expq.pop_front();
                    chk(cur_op == exp_op, "R1/R2/R4/R5 bus operation", 32'(cur_op), 32'(exp_op));
                end
                txn_no++;
                r_data = 16'h5A5A;
                r_err  = 1'b0;
                if (txn_no == err_idx_v) begin
                    r_err  = 1'b1;
                    r_data = 16'hDEAD;
                end else if (sw_addr != 5'd0 && bus_req_phy == sw_addr) begin
                    if (bus_req_reg == 5'd0) begin
                        if (!bus_req_write) begin
                            if (busy_left > 0) begin
                                r_data = 16'h9234;
                                busy_left--;
                            end else begin
                                r_data = 16'h0C21;
                            end
                        end else begin
                            busy_left = post_busy_v;
                            if (bus_req_wdata[11]) t_data = tmem[bus_req_wdata[9:5]][bus_req_wdata[4:0]];
                            else if (bus_req_wdata[10]) tmem[bus_req_wdata[9:5]][bus_req_wdata[4:0]] = t_data;
                        end
                    end else if (bus_req_reg == 5'd1) begin
                        if (!bus_req_write) r_data = t_data;
                        else t_data = bus_req_wdata;
                    end
                end else begin
                    if (!bus_req_write) r_data = tmem[bus_req_phy][bus_req_reg];
                    else tmem[bus_req_phy][bus_req_reg] = bus_req_wdata;
                end
                pend  = 1'b1;
                pcnt  = rsp_lat;
                perr  = r_err;
                pdata = r_data;
            end
        end
    end

    task automatic push_polls(input int busy);
        int n = (busy >= 16) ? 16 : busy + 1;
        for (int i = 0; i < n; i++) expq.push_back({1'b0, sw_addr, 5'd0, 16'h0000});
    endtask

    task automatic do_req(input bit w, input logic [4:0] dev, input logic [4:0] rg,
                          input logic [15:0] wd, input int pre, input int post,
                          input int eidx, input string tag);
        bit          e_err = 1'b0;
        bit          e_tmo = 1'b0;
        logic [15:0] e_rd = '0;
        bit          r7_ok = 1'b1;
        int          k = 0;
        expq.delete();
        if (sw_addr == 5'd0) begin
            expq.push_back({w, dev, rg, w ? wd : 16'h0000});
        end else begin
            push_polls(pre);
            if (pre >= 16) begin
                e_tmo = 1'b1;
            end else begin
                if (w) expq.push_back({1'b1, sw_addr, 5'd1, wd});
                expq.push_back({1'b1, sw_addr, 5'd0,
                                (w ? 16'h9400 : 16'h9800) | (16'(dev) << 5) | 16'(rg)});
                push_polls(post);
                if (post >= 16) e_tmo = 1'b1;
                else if (!w) expq.push_back({1'b0, sw_addr, 5'd1, 16'h0000});
            end
        end
        if (!w && !e_tmo) e_rd = tmem[dev][rg];
        if (eidx > 0 && eidx <= expq.size()) begin
            while (expq.size() > eidx) void'(expq.pop_back());
            e_err = 1'b1;
            e_tmo = 1'b0;
            e_rd  = '0;
        end
        if (e_tmo) e_rd = '0;
        txn_no = 0;
        err_idx_v = eidx;
        busy_left = pre;
        post_busy_v = post;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = w;
        req_dev   = dev;
        req_reg   = rg;
        req_wdata = wd;
        while (!req_ready && k < 100) begin
            @(negedge clk);
            k++;
        end
        @(negedge clk);
        req_valid = 1'b0;
        k = 0;
        while (!cpl_valid && k < 3000) begin
            if (req_ready) r7_ok = 1'b0;
            @(negedge clk);
            k++;
        end
        chk(r7_ok, {"R7 ready low while busy: ", tag}, 32'(r7_ok), 32'h1);
        if (!cpl_valid) begin
            chk(1'b0, {"R7 completion never came: ", tag}, 32'h0, 32'h1);
        end else begin
            chk(cpl_err == e_err, {"R6 error flag: ", tag}, 32'(cpl_err), 32'(e_err));
            chk(cpl_timeout == e_tmo, {"R3 timeout flag: ", tag}, 32'(cpl_timeout), 32'(e_tmo));
            chk(cpl_rdata == e_rd, {"R4/R9 read data: ", tag}, 32'(cpl_rdata), 32'(e_rd));
            chk(req_ready, {"R7 ready at completion: ", tag}, 32'(req_ready), 32'h1);
            chk(expq.size() == 0, {"R6 missing bus operations: ", tag}, 32'(expq.size()), 32'h0);
            @(negedge clk);
            chk(!cpl_valid, {"R9 single-cycle completion: ", tag}, 32'(cpl_valid), 32'h0);
        end
    endtask

    initial begin
        #(20 * 150000);
        chk(1'b0, "watchdog expired", 32'h0, 32'h1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int d = 0; d < 32; d++)
            for (int r = 0; r < 32; r++)
                tmem[d][r] = 16'(d * 37 + r * 5 + 16'h1000);
        repeat (3) @(negedge clk);
        chk(req_ready && !bus_req_valid && !cpl_valid, "R10 state in reset",
            {29'h0, req_ready, bus_req_valid, cpl_valid}, 32'h4);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !bus_req_valid && !cpl_valid, "R10 state after reset",
            {29'h0, req_ready, bus_req_valid, cpl_valid}, 32'h4);

        sw_addr = 5'd0;
        do_req(1'b0, 5'd3, 5'd7, 16'h0000, 0, 0, 0, "R1 direct read");
        do_req(1'b1, 5'd3, 5'd7, 16'hBEEF, 0, 0, 0, "R1 direct write");
        do_req(1'b0, 5'd3, 5'd7, 16'h0000, 0, 0, 0, "R1 direct read back");
        do_req(1'b0, 5'd4, 5'd1, 16'h0000, 0, 0, 1, "R6 direct error");

        sw_addr = 5'd17;
        do_req(1'b0, 5'd2, 5'd5, 16'h0000, 0, 0, 0, "R4 indirect read");
        stall_mode = 1'b1;
        rsp_lat = 2;
        do_req(1'b0, 5'd31, 5'd31, 16'h0000, 3, 5, 0, "R2 R8 polled read with stalls");
        stall_mode = 1'b0;
        rsp_lat = 0;
        do_req(1'b1, 5'd9, 5'd30, 16'h1234, 2, 1, 0, "R5 indirect write");
        do_req(1'b0, 5'd9, 5'd30, 16'h0000, 0, 0, 0, "R5 read back");
        do_req(1'b0, 5'd1, 5'd0, 16'h0000, 15, 15, 0, "R3 fifteen busy reads");
        do_req(1'b0, 5'd1, 5'd0, 16'h0000, 16, 0, 0, "R3 timeout before command");
        do_req(1'b1, 5'd6, 5'd2, 16'hA5A5, 0, 16, 0, "R3 timeout after write");
        do_req(1'b0, 5'd8, 5'd8, 16'h0000, 0, 0, 1, "R6 error on first poll");
        do_req(1'b1, 5'd8, 5'd8, 16'h7777, 0, 0, 3, "R6 error on command");
        do_req(1'b0, 5'd8, 5'd8, 16'h0000, 0, 0, 4, "R6 error on data read");
        do_req(1'b0, 5'd8, 5'd8, 16'h0000, 1, 1, 0, "R4 read after errors");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule